// File: doc/BRIEF.md
# UART Hardware Flow Control

This block performs automatic RTS/CTS handshaking for a UART. On the receive side it compares the receive FIFO fill level with a programmable threshold and drives the RTS pin from a flop. When the FIFO is close to full, the pin tells the far end to pause.

On the transmit side it synchronises the incoming CTS pin through two flops. It then produces a qualifier that the transmitter consults before it starts each new character. A character that has already started is not affected. That is the transmitter's concern, because this qualifier only gates starts.

Both directions take their enable and polarity-invert controls straight from the UART control word. The bit positions match the register decoder that feeds it. The FIFOs, the baud generator and the register decoding are outside this block.

Top module: `uart_flow_ctl`

## Requirements
- R1: While reset is asserted, rts_o is 0 and the CTS synchroniser holds a pin level of 1. With CTS flow control enabled and no inversion, this makes tx_allow_o 0.
- R2: When control bit 18 (RTS enable) is 0, RTS stays asserted whatever the receive level. The pin then shows the asserted level: 0, or 1 when bit 21 is set.
- R3: Control bits [20:19] select the RTS threshold: 0 selects 8, 1 selects 16, 2 selects 32 and 3 selects 48 received characters.
- R4: With RTS enabled, RTS is deasserted when rx_level_i is at or above the threshold. It is asserted again when the level is below the threshold. rts_o shows the change one clock edge after the inputs.
- R5: Control bit 21 inverts the RTS pin. With the bit clear, asserted is 0 and deasserted is 1. With the bit set, asserted is 1 and deasserted is 0.
- R6: When control bit 14 (CTS enable) is 0, tx_allow_o is 1 regardless of the CTS pin.
- R7: When CTS is enabled and control bit 15 is 0, a synchronised pin level of 0 means asserted and gives tx_allow_o = 1. A level of 1 gives tx_allow_o = 0.
- R8: Control bit 15 inverts the CTS input. With the bit set, a synchronised level of 1 means asserted.
- R9: A change on cts_i reaches tx_allow_o after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | CTRL_W | UART control word; bits 14, 15, 18, 19-20 and 21 are used |
| rx_level_i | input | LVL_W | Current receive FIFO fill level |
| cts_i | input | 1 | Asynchronous CTS pin |
| tx_allow_o | output | 1 | 1 when the transmitter may start a new character |
| rts_o | output | 1 | Registered RTS pin level |

## Verification
A wrong threshold decode shows at rts_o one edge after the level crosses the selected boundary. A wrong polarity shows on the very next edge at any level. A fault in the synchroniser depth or its reset value shows at tx_allow_o, either in the reset cycles or exactly two edges after a CTS change. The check sweeps each threshold at its boundary pair and compares random mixes of control bits, levels and pin values against a per-cycle model.

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int LVL_W       = 7,
  parameter int CTRL_W      = 32,
  parameter int CTS_EN_BIT  = 14,
  parameter int CTS_INV_BIT = 15,
  parameter int RTS_EN_BIT  = 18,
  parameter int RTS_SEL_LSB = 19,
  parameter int RTS_INV_BIT = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              cts_i,
  output logic              tx_allow_o,
  output logic              rts_o
);
  localparam int THR_W = (LVL_W > 6) ? LVL_W + 1 : 7;

  wire        rts_en  = ctrl_i[RTS_EN_BIT];
  wire        rts_inv = ctrl_i[RTS_INV_BIT];
  wire [1:0]  rts_sel = ctrl_i[RTS_SEL_LSB +: 2];
  wire        cts_en  = ctrl_i[CTS_EN_BIT];
  wire        cts_inv = ctrl_i[CTS_INV_BIT];
  wire        unused_ctrl = ^ctrl_i;

  wire [THR_W-1:0] thr   = (rts_sel == 2'd0) ? THR_W'(8) : (THR_W'(rts_sel) << 4);
  wire [THR_W-1:0] level = THR_W'(rx_level_i);
  wire             stop  = rts_en && (level >= thr);

  logic cts_s1, cts_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1 <= 1'b1;
      cts_s2 <= 1'b1;
      rts_o  <= 1'b0;
    end else begin
      cts_s1 <= cts_i;
      cts_s2 <= cts_s1;
      rts_o  <= stop ^ rts_inv;
    end
  end

  assign tx_allow_o = !cts_en || !(cts_s2 ^ cts_inv);

  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd2)  cyc_q <= cyc_q + 2'd1;
  end

  assert_rts_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en |=> rts_o == $past(rts_inv));

  assert_rts_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && rx_level_i >= LVL_W'(48)) |=> rts_o != $past(rts_inv));

  assert_rts_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en && rx_level_i < LVL_W'(8)) |=> rts_o == $past(rts_inv));

  assert_cts_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cts_en |-> tx_allow_o);

  assert_cts_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_en && (cyc_q == 2'd2)) |-> tx_allow_o == !($past(cts_i, 2) ^ cts_inv));
endmodule

// File: tb/uart_flow_ctl_tb_top.sv
module uart_flow_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl = 32'h0;
  logic [6:0]  lvl = 7'd0;
  logic        cts = 1'b1;
  logic        allow, rts;
  int checks = 0, fails = 0;
  bit done = 0;
  logic m1 = 1'b1, m2 = 1'b1;

  always #5 clk = ~clk;

  uart_flow_ctl dut_i (.clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .rx_level_i(lvl),
                       .cts_i(cts), .tx_allow_o(allow), .rts_o(rts));

  function automatic int exp_thr(logic [1:0] sel);
    return (sel == 2'd0) ? 8 : 16 * int'(sel);
  endfunction

  function automatic logic exp_rts(logic [31:0] c, logic [6:0] l);
    logic stop;
    stop = c[18] && (int'(l) >= exp_thr(c[20:19]));
    return stop ^ c[21];
  endfunction

  function automatic logic exp_allow(logic [31:0] c, logic s2);
    return !c[14] || ((s2 ^ c[15]) == 1'b0);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    m2 = m1;
    m1 = cts;
    #1;
  endtask

  task automatic rts_case(string req, logic [31:0] c, int l);
    @(negedge clk);
    ctrl = c; lvl = 7'(l);
    cyc();
    check(req, rts, exp_rts(c, 7'(l)));
  endtask

  initial begin
    ctrl = 32'h0000_4000;
    #12;
    check("R1 rts in reset", rts, 1'b0);
    check("R1 allow in reset", allow, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      logic [31:0] c;
      c = 32'h0004_0000 | (32'(s) << 19);
      rts_case("R3 below threshold", c, exp_thr(2'(s)) - 1);
      check("R4 asserted below", rts, 1'b0);
      rts_case("R3 at threshold", c, exp_thr(2'(s)));
      check("R4 deasserted at", rts, 1'b1);
    end
    rts_case("R2 disabled full", 32'h0000_0000, 64);
    check("R2 pin low", rts, 1'b0);
    rts_case("R5 inverted asserted", 32'h0024_0000, 0);
    check("R5 pin high", rts, 1'b1);
    rts_case("R5 inverted full", 32'h0024_0000, 60);
    check("R5 pin low", rts, 1'b0);

    @(negedge clk); ctrl = 32'h0000_4000; cts = 1'b1;
    cyc(); cyc();
    check("R7 deasserted", allow, 1'b0);
    @(negedge clk); cts = 1'b0;
    cyc();
    check("R9 one edge", allow, 1'b0);
    cyc();
    check("R9 two edges", allow, 1'b1);
    @(negedge clk); ctrl = 32'h0000_C000;
    #1 check("R8 inverted low pin", allow, 1'b0);
    @(negedge clk); ctrl = 32'h0000_0000; cts = 1'b1;
    cyc(); cyc();
    check("R6 disabled", allow, 1'b1);

    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ctrl = ($urandom() & 32'h003C_C000);
      lvl = 7'($urandom_range(0, 70));
      cts = 1'($urandom());
      cyc();
      check("R4 random rts", rts, exp_rts(ctrl, lvl));
      check("R7 random allow", allow, exp_allow(ctrl, m2));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule